// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A tick enable runs at a fixed multiple of the bit rate: sixteen ticks per bit in normal speed, or eight when double speed is selected. The block counts these ticks from the falling edge of a start bit. Three neighbouring samples around each bit centre are combined by majority vote. A start edge that does not hold up at its centre is treated as noise and discarded.

The character length, parity mode and multiprocessor filtering are set by static configuration inputs. Each completed character is pushed, with its own framing and parity flags, into a two-entry buffer. The consumer sees the oldest entry at the outputs and removes it with a one-cycle read strobe. If a character completes while both entries are occupied, it is lost, and an overrun flag is attached to the newest stored entry.

Top module: `serial_rx_core`

## Requirements
- R1: `dataLen` selects the character length: codes 0 to 4 give 5 to 9 bits, and codes above 4 give 9 bits. Bits arrive least significant first. `rxData` holds the character right-aligned, with every bit above the length at zero.
- R2: `parityMode` 2'b10 expects even parity and 2'b11 expects odd parity over the data bits plus one parity bit that follows them. The codes 2'b00 and 2'b01 mean no parity bit is present. `parityErr` is set on a mismatch.
- R3: `frameErr` is set when the first stop bit votes low. A second stop bit is never examined; it is treated as idle line.
- R4: A bit lasts 16 ticks, or 8 ticks when `dblSpeed` is 1. Counting from the first tick that sees the line low as 0, the bit value is the majority of ticks 7, 8 and 9 (3, 4 and 5 in double speed). A single wrong sample inside that window does not change the bit.
- R5: A start edge whose centre vote is high is dropped, and nothing is stored for it.
- R6: Up to two characters are buffered. The oldest is shown on `rxData`, `frameErr`, `parityErr` and `overrun`, and stays stable until `rdStrobe` removes it. Each character's flags move with it.
- R7: A character that completes while the buffer is full is discarded. `overrun` is then set on the most recently stored character.
- R8: `rxValid` is 1 exactly while the buffer holds at least one character.
- R9: With `mpMode` at 1, a character whose last data bit (bit 8 in the 9-bit format) is 0 is dropped without entering the buffer.
- R10: Line sampling and frame state advance only in cycles where `baudTick` is 1.
- R11: After reset the buffer is empty: `rxValid` is 0 and `rxData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Raw serial line, idle high |
| baudTick | input | 1 | Oversampling tick enable |
| dataLen | input | 3 | Character length code |
| parityMode | input | 2 | Parity: 0x none, 10 even, 11 odd |
| dblSpeed | input | 1 | 8 ticks per bit instead of 16 |
| mpMode | input | 1 | Drop characters whose last data bit is 0 |
| rdStrobe | input | 1 | Remove the oldest buffered character |
| rxData | output | 9 | Oldest character, right-aligned |
| frameErr | output | 1 | Framing error of the oldest character |
| parityErr | output | 1 | Parity error of the oldest character |
| overrun | output | 1 | A later character was lost after this one |
| rxValid | output | 1 | Buffer not empty |

## Verification
A table of frames covers every length from five to nine bits, each parity mode, both speeds, a second stop bit, a forced parity fault and a low stop bit. This separates length alignment errors from parity and framing errors. A frame with single-cycle glitches placed on each of the three voting samples in turn tells a real majority vote apart from single-point sampling. A short low pulse on an idle line tests false-start rejection. Further cases cover three back-to-back frames with no reads (buffer depth, overrun placement and flags moving with each character), address filtering at two lengths, and a frame sent with a tick every second cycle, which shows that timing follows the tick rather than the clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS = 9;

  typedef struct packed {
    logic smp;       // take a line sample
    logic clrFrame;  // new frame begins
    logic shiftBit;  // data bit vote ready
    logic takePar;   // parity bit vote ready
    logic finish;    // first stop bit vote ready
  } srxStrobe_t;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic fe;
    logic pe;
    logic ovr;
  } srxEntry_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       lineS,
  input  logic       vote,
  input  logic       dblSpeed,
  input  logic [3:0] nBits,
  input  logic       parEn,
  output srxStrobe_t stb
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
  localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] VOTE_N = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] VOTE_D = CW'(OSR / 4 + 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} rxState_t;

  rxState_t state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt, voteCnt;
  logic [3:0] bitIdx;
  logic voteNow, endBit, startSeen;

  always_comb begin
    lastCnt   = dblSpeed ? LAST_D : LAST_N;
    voteCnt   = dblSpeed ? VOTE_D : VOTE_N;
    voteNow   = baudTick && (state != IDLE) && (cnt == voteCnt);
    endBit    = baudTick && (state != IDLE) && (cnt == lastCnt);
    startSeen = baudTick && (state == IDLE) && !lineS;
    stb.smp      = baudTick;
    stb.clrFrame = startSeen;
    stb.shiftBit = voteNow && (state == DATA);
    stb.takePar  = voteNow && (state == PAR);
    stb.finish   = voteNow && (state == STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (baudTick) begin
      if (state != IDLE) cnt <= (cnt == lastCnt) ? '0 : cnt + CW'(1);
      case (state)
        IDLE: if (!lineS) begin
          state <= START;
          cnt   <= CW'(1);
        end
        START: begin
          if (voteNow && vote) state <= IDLE;
          else if (endBit) begin
            state  <= DATA;
            bitIdx <= '0;
          end
        end
        DATA: if (endBit) begin
          if (bitIdx == nBits - 4'd1) state <= parEn ? PAR : STOP;
          bitIdx <= bitIdx + 4'd1;
        end
        PAR:  if (endBit) state <= STOP;
        STOP: if (voteNow) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  srxStrobe_t          stb,
  input  logic [3:0]          nBits,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic                mpMode,
  input  logic                rdStrobe,
  output logic                lineS,
  output logic                vote,
  output logic [MAX_BITS-1:0] rxData,
  output logic                frameErr,
  output logic                parityErr,
  output logic                overrun,
  output logic                rxValid
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULL = NW'(DEPTH);

  logic [1:0] syncQ;
  logic [1:0] smpQ;
  logic [MAX_BITS-1:0] shReg;
  logic parAcc;
  srxEntry_t mem [DEPTH];
  srxEntry_t newEnt;
  logic [NW-1:0] count, cntAfterPop;
  logic pop, push, drop;

  assign lineS = syncQ[1];
  assign vote  = (smpQ[1] & smpQ[0]) | (smpQ[1] & lineS) | (smpQ[0] & lineS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      smpQ   <= 2'b11;
      shReg  <= '0;
      parAcc <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (stb.smp) smpQ <= {smpQ[0], lineS};
      if (stb.clrFrame) begin
        shReg  <= '0;
        parAcc <= 1'b0;
      end else if (stb.shiftBit) begin
        shReg  <= {vote, shReg[MAX_BITS-1:1]};
        parAcc <= parAcc ^ vote;
      end else if (stb.takePar) begin
        parAcc <= parAcc ^ vote;
      end
    end
  end

  always_comb begin
    newEnt.data = shReg >> (4'd9 - nBits);
    newEnt.fe   = !vote;
    newEnt.pe   = parEn && (parAcc ^ parOdd);
    newEnt.ovr  = 1'b0;
    drop        = mpMode && !shReg[MAX_BITS-1];
    push        = stb.finish && !drop;
    pop         = rdStrobe && (count != '0);
    cntAfterPop = count - NW'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
        mem[DEPTH-1] <= '0;
      end
      if (push) begin
        if (cntAfterPop < FULL) mem[cntAfterPop[PW-1:0]] <= newEnt;
        else mem[DEPTH-1].ovr <= 1'b1;
      end
      count <= cntAfterPop + NW'(push && (cntAfterPop < FULL));
    end
  end

  assign rxData    = mem[0].data;
  assign frameErr  = mem[0].fe;
  assign parityErr = mem[0].pe;
  assign overrun   = mem[0].ovr;
  assign rxValid   = (count != '0);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic                baudTick,
  input  logic [2:0]          dataLen,
  input  logic [1:0]          parityMode,
  input  logic                dblSpeed,
  input  logic                mpMode,
  input  logic                rdStrobe,
  output logic [MAX_BITS-1:0] rxData,
  output logic                frameErr,
  output logic                parityErr,
  output logic                overrun,
  output logic                rxValid
);
  srxStrobe_t stb;
  logic lineS, vote;
  logic [3:0] nBits;

  assign nBits = (dataLen > 3'd4) ? 4'd9 : 4'd5 + {1'b0, dataLen};

  srx_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lineS(lineS), .vote(vote),
    .dblSpeed(dblSpeed), .nBits(nBits), .parEn(parityMode[1]), .stb(stb)
  );

  srx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .stb(stb), .nBits(nBits),
    .parEn(parityMode[1]), .parOdd(parityMode[0]), .mpMode(mpMode),
    .rdStrobe(rdStrobe), .lineS(lineS), .vote(vote), .rxData(rxData),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun),
    .rxValid(rxValid)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       baudTick,
  input logic       rdStrobe,
  input logic [8:0] rxData,
  input logic       frameErr,
  input logic       parityErr,
  input logic       overrun,
  input logic       rxValid
);
  // R8
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxValid) |-> $past(rdStrobe));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdStrobe) |=> ($stable(rxData) && $stable(frameErr) && $stable(parityErr)));

  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !rdStrobe) |=> ($stable(rxValid) && $stable(rxData) && $stable(overrun)));

  // R7
  ovr_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxValid);
endmodule

bind serial_rx_core srx_chk u_chk (.*);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, rxLine = 1'b1, baudTick = 1'b1, dblSpeed = 1'b0;
  logic mpMode = 1'b0, rdStrobe = 1'b0, tickHalf = 1'b0;
  logic [2:0] dataLen = 3'd3;
  logic [1:0] parityMode = 2'd0;
  logic [8:0] rxData;
  logic frameErr, parityErr, overrun, rxValid;
  int total = 0, bad = 0;
  bit done = 0;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .dataLen(dataLen), .parityMode(parityMode), .dblSpeed(dblSpeed),
    .mpMode(mpMode), .rdStrobe(rdStrobe), .rxData(rxData),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun),
    .rxValid(rxValid)
  );

  always @(negedge clk) baudTick <= tickHalf ? ~baudTick : 1'b1;

  typedef struct packed {
    logic [2:0] len;
    logic [1:0] par;
    logic two, dbl, badPar, stopLow;
    logic [8:0] data, expData;
    logic expFe, expPe;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
    '{3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 9'h013, 9'h013, 1'b0, 1'b0},
    '{3'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3, 9'h1C3, 1'b0, 1'b0},
    '{3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 9'h055, 9'h055, 1'b0, 1'b0},
    '{3'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 9'h03C, 9'h03C, 1'b0, 1'b1},
    '{3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h081, 9'h081, 1'b1, 1'b0},
    '{3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h02A, 9'h02A, 1'b0, 1'b0},
    '{3'd4, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0F0, 9'h0F0, 1'b1, 1'b1},
    '{3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0FF, 9'h01F, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch: data bits 0,1,2 get a one-cycle flip at offsets 7,8,9
  task automatic sendFrame(input logic [8:0] d, input int nb, input logic parEn,
                           input logic parOdd, input logic badPar, input logic stopLow,
                           input logic twoSt, input int per, input logic glitch);
    logic p;
    p = parOdd ^ badPar;
    driveBit(1'b0, per);
    for (int i = 0; i < nb; i++) begin
      p = p ^ d[i];
      if (glitch && i < 3) begin
        driveBit(d[i], 7 + i);
        driveBit(~d[i], 1);
        driveBit(d[i], per - 8 - i);
      end else driveBit(d[i], per);
    end
    if (parEn) driveBit(p, per);
    driveBit(~stopLow, per);
    if (twoSt) driveBit(1'b1, per);
    driveBit(1'b1, 2 * per);
  endtask

  task automatic popOne();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 16'(rxValid), 16'h0);
    check("R11 data", 16'(rxData), 16'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 9; k++) begin
      dataLen = VECS[k].len;
      parityMode = VECS[k].par;
      dblSpeed = VECS[k].dbl;
      sendFrame(VECS[k].data, 5 + int'(VECS[k].len), VECS[k].par[1], VECS[k].par[0],
                VECS[k].badPar, VECS[k].stopLow, VECS[k].two, VECS[k].dbl ? 8 : 16, 1'b0);
      check("R8 valid after frame", 16'(rxValid), 16'h1);
      check("R1 data", 16'(rxData), 16'(VECS[k].expData));
      check("R3 frame flag", 16'(frameErr), 16'(VECS[k].expFe));
      check("R2 parity flag", 16'(parityErr), 16'(VECS[k].expPe));
      check("R7 no overrun", 16'(overrun), 16'h0);
      popOne();
      check("R8 empty after read", 16'(rxValid), 16'h0);
    end
    dblSpeed = 1'b0;
    parityMode = 2'd0;
    dataLen = 3'd3;

    // R4 majority vote with glitches on each voting sample
    sendFrame(9'h05A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b1);
    check("R4 glitch-free data", 16'(rxData), 16'h05A);
    popOne();

    // R5 false start
    driveBit(1'b0, 4);
    driveBit(1'b1, 48);
    check("R5 nothing stored", 16'(rxValid), 16'h0);
    sendFrame(9'h03A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R5 recovery data", 16'(rxData), 16'h03A);
    popOne();

    // R10 tick every second cycle
    tickHalf = 1'b1;
    sendFrame(9'h06E, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32, 1'b0);
    check("R10 slow tick data", 16'(rxData), 16'h06E);
    popOne();
    tickHalf = 1'b0;
    repeat (2) @(negedge clk);

    // R6 / R7 three frames without reading
    sendFrame(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    sendFrame(9'h022, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16, 1'b0);
    sendFrame(9'h033, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R6 head first", 16'(rxData), 16'h011);
    check("R6 head flags", 16'({frameErr, overrun}), 16'h0);
    popOne();
    check("R6 second data", 16'(rxData), 16'h022);
    check("R6 flag travels", 16'(frameErr), 16'h1);
    check("R7 overrun on newest", 16'(overrun), 16'h1);
    popOne();
    check("R7 lost frame gone", 16'(rxValid), 16'h0);

    // R9 multiprocessor filtering
    mpMode = 1'b1;
    dataLen = 3'd4;
    sendFrame(9'h055, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R9 9-bit dropped", 16'(rxValid), 16'h0);
    sendFrame(9'h155, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R9 9-bit kept", 16'(rxData), 16'h155);
    popOne();
    dataLen = 3'd3;
    sendFrame(9'h07F, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R9 8-bit dropped", 16'(rxValid), 16'h0);
    sendFrame(9'h080, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    check("R9 8-bit kept", 16'(rxData), 16'h080);
    popOne();
    mpMode = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule